// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit sits between instruction decode and the data memory port of a 16-bit load/store processor. Given a decoded instruction word, the already-incremented program counter and the value read from the register file for the base field, it works out where the instruction touches memory or where control goes next. The result is presented as registered memory strobes with an address, a jump request with its target, and a link write carrying the return address for subroutine calls.

Three address forms are handled. The program-counter-relative form adds a 9-bit signed offset to the incremented PC. The base-plus-offset form adds a 6-bit signed offset to a register value. The indirect form reads a pointer word from memory at the PC-relative address, then uses that word as the final address. Calls use an 11-bit signed PC-relative offset or a register target, and both write the return address into register 7. A plain jump through a register serves as the subroutine return when that register is 7.

The memory is assumed to return read data in the cycle after the cycle in which the read strobe is seen. An internal sequencer handles the second access of indirect operations and raises `busy` while it does so.

Top module: `ea_unit`

## Requirements
- R1: After a synchronous reset, `mem_rd`, `mem_wr`, `busy`, `jump_valid` and `link_we` are all low and stay low until a valid `start`.
- R2: For opcode 0010 (load) or 0011 (store), one cycle after `start` the unit presents `mem_addr` = `pc_inc` + sign-extended `instr[8:0]`, with `mem_rd` (load) or `mem_wr` (store) high for exactly one cycle and `reg_idx` = `instr[11:9]`.
- R3: For opcode 0110 (load) or 0111 (store), the address is `base_val` + sign-extended `instr[5:0]`, with strobes and `reg_idx` as in R2.
- R4: For opcode 1010 (indirect load) or 1011 (indirect store), the first cycle after `start` reads at `pc_inc` + sign-extended `instr[8:0]` with `busy` high; the next cycle has `busy` high and no strobe; the cycle after that issues the final read or write at the word memory returned, with `busy` low.
- R5: For opcode 0100 with `instr[11]` = 1, one cycle after `start` the unit raises `jump_valid` with target `pc_inc` + sign-extended `instr[10:0]`, and raises `link_we` with `link_data` = `pc_inc` and `reg_idx` = 7.
- R6: For opcode 0100 with `instr[11]` = 0, the target is `base_val` and the link write is as in R5; when the base register is 7, the target is the value presented before the link write.
- R7: For opcode 1100 the target is `base_val` with `jump_valid` high and no link write; with base register 7 this is the subroutine return.
- R8: A `start` that arrives while `busy` is high is ignored: the indirect access completes unchanged and no extra strobe or jump appears.
- R9: Any other opcode produces no memory strobe, no jump and no link write.
- R10: All address additions wrap modulo 2^16.
- R11: In any cycle at most one of `mem_rd`, `mem_wr` and `jump_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction valid for one cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the instruction plus one |
| base_val | input | 16 | Register value selected by `instr[8:6]` |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read strobe |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| reg_idx | output | 3 | Destination or source register index |
| busy | output | 1 | Indirect sequence in progress |
| jump_valid | output | 1 | Control transfer request |
| jump_target | output | 16 | New PC for the transfer |
| link_we | output | 1 | Write return address to register 7 |
| link_data | output | 16 | Return address |

## Verification
The bench builds the unit with its default widths: a 16-bit word, a 3-bit register index and offsets of 9, 6 and 11 bits. At these sizes the most negative and most positive offsets, and PC and base values near 0x0000 and 0xFFFF, can be driven directly, so wraparound in both directions is exercised. The memory model returns a word scrambled from the pointer address. This shows that the second indirect access uses the data from the first read rather than the pointer address itself.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LD   = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_ST   = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_CALL = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_LDR  = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_STR  = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_LDI  = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_STI  = 4'b1011;
  localparam logic [OPC_W-1:0] OPC_JMP  = 4'b1100;

  typedef enum logic [3:0] {
    K_NONE,
    K_LD,
    K_ST,
    K_LDI,
    K_STI,
    K_LDR,
    K_STR,
    K_JSR,
    K_JSRR,
    K_JMP
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PTR,
    S_WAIT
  } seq_state_t;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             call_pc_rel,
  output kind_t            kind
);

  always_comb begin
    kind = K_NONE;
    case (opcode)
      OPC_LD:   kind = K_LD;
      OPC_ST:   kind = K_ST;
      OPC_LDI:  kind = K_LDI;
      OPC_STI:  kind = K_STI;
      OPC_LDR:  kind = K_LDR;
      OPC_STR:  kind = K_STR;
      OPC_CALL: kind = call_pc_rel ? K_JSR : K_JSRR;
      OPC_JMP:  kind = K_JMP;
      default:  kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic [DATA_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] sum
);

  logic [DATA_W-1:0] off_ext;

  generate
    if (OFF_W < DATA_W) begin : g_ext
      assign off_ext = {{(DATA_W-OFF_W){off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[DATA_W-1:0];
    end
  endgenerate

  // Plain width-limited add: carry out is dropped, so the result wraps.
  assign sum = base + off_ext;

endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_W    = 3,
  parameter int LINK_REG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  kind_t             kind,
  input  logic [REG_W-1:0]  reg_fld,
  input  logic [DATA_W-1:0] addr_pcrel,
  input  logic [DATA_W-1:0] addr_base,
  input  logic [DATA_W-1:0] addr_call,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [REG_W-1:0]  reg_idx,
  output logic              busy,
  output logic              jump_valid,
  output logic [DATA_W-1:0] jump_target,
  output logic              link_we,
  output logic [DATA_W-1:0] link_data
);

  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  seq_state_t state;
  logic       pend_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_addr    <= '0;
      mem_rd      <= 1'b0;
      mem_wr      <= 1'b0;
      reg_idx     <= '0;
      busy        <= 1'b0;
      jump_valid  <= 1'b0;
      jump_target <= '0;
      link_we     <= 1'b0;
      link_data   <= '0;
      pend_st     <= 1'b0;
    end else begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      jump_valid <= 1'b0;
      link_we    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            reg_idx <= reg_fld;
            case (kind)
              K_LD: begin
                mem_addr <= addr_pcrel;
                mem_rd   <= 1'b1;
              end
              K_ST: begin
                mem_addr <= addr_pcrel;
                mem_wr   <= 1'b1;
              end
              K_LDR: begin
                mem_addr <= addr_base;
                mem_rd   <= 1'b1;
              end
              K_STR: begin
                mem_addr <= addr_base;
                mem_wr   <= 1'b1;
              end
              K_LDI, K_STI: begin
                mem_addr <= addr_pcrel;
                mem_rd   <= 1'b1;
                busy     <= 1'b1;
                pend_st  <= (kind == K_STI);
                state    <= S_PTR;
              end
              K_JSR: begin
                jump_valid  <= 1'b1;
                jump_target <= addr_call;
                link_we     <= 1'b1;
                link_data   <= pc_inc;
                reg_idx     <= LINK_IDX;
              end
              K_JSRR: begin
                // base_val is the register value before the link write lands.
                jump_valid  <= 1'b1;
                jump_target <= base_val;
                link_we     <= 1'b1;
                link_data   <= pc_inc;
                reg_idx     <= LINK_IDX;
              end
              K_JMP: begin
                jump_valid  <= 1'b1;
                jump_target <= base_val;
              end
              default: ;
            endcase
          end
        end
        S_PTR: begin
          // The memory samples the pointer read on this edge.
          state <= S_WAIT;
        end
        S_WAIT: begin
          mem_addr <= mem_rdata;
          mem_rd   <= ~pend_st;
          mem_wr   <= pend_st;
          busy     <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_action_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, jump_valid}));

  assert_ptr_then_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rd) |=> (busy && !mem_rd && !mem_wr));

  assert_wait_then_final_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rd) |=> (!busy && (mem_rd || mem_wr)));

  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!mem_wr && !jump_valid));

  assert_link_on_call_R5: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (jump_valid && reg_idx == LINK_IDX && !busy));

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_W    = 3,
  parameter int PCOFF_W  = 9,
  parameter int BOFF_W   = 6,
  parameter int COFF_W   = 11,
  parameter int LINK_REG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [REG_W-1:0]  reg_idx,
  output logic              busy,
  output logic              jump_valid,
  output logic [DATA_W-1:0] jump_target,
  output logic              link_we,
  output logic [DATA_W-1:0] link_data
);

  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int REG_LSB = PCOFF_W;
  localparam int CALL_FLAG_BIT = COFF_W;

  kind_t             kind;
  logic [DATA_W-1:0] addr_pcrel;
  logic [DATA_W-1:0] addr_base;
  logic [DATA_W-1:0] addr_call;

  ea_decode u_dec (
    .opcode      (instr[DATA_W-1:OPC_LSB]),
    .call_pc_rel (instr[CALL_FLAG_BIT]),
    .kind        (kind)
  );

  ea_adder #(.DATA_W(DATA_W), .OFF_W(PCOFF_W)) u_add_pc (
    .base (pc_inc),
    .off  (instr[PCOFF_W-1:0]),
    .sum  (addr_pcrel)
  );

  ea_adder #(.DATA_W(DATA_W), .OFF_W(BOFF_W)) u_add_base (
    .base (base_val),
    .off  (instr[BOFF_W-1:0]),
    .sum  (addr_base)
  );

  ea_adder #(.DATA_W(DATA_W), .OFF_W(COFF_W)) u_add_call (
    .base (pc_inc),
    .off  (instr[COFF_W-1:0]),
    .sum  (addr_call)
  );

  ea_seq #(.DATA_W(DATA_W), .REG_W(REG_W), .LINK_REG(LINK_REG)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .kind        (kind),
    .reg_fld     (instr[REG_LSB+REG_W-1:REG_LSB]),
    .addr_pcrel  (addr_pcrel),
    .addr_base   (addr_base),
    .addr_call   (addr_call),
    .base_val    (base_val),
    .pc_inc      (pc_inc),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .reg_idx     (reg_idx),
    .busy        (busy),
    .jump_valid  (jump_valid),
    .jump_target (jump_target),
    .link_we     (link_we),
    .link_data   (link_data)
  );

endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, mem_rdata = '0;
  logic [15:0] mem_addr, jump_target, link_data;
  logic        mem_rd, mem_wr, busy, jump_valid, link_we;
  logic [2:0]  reg_idx;
  int checks = 0, errors = 0;

  ea_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] scramble(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h1234;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= scramble(mem_addr);

  function automatic logic [15:0] sx(input logic [15:0] v, input int w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] i, input logic [15:0] pc, input logic [15:0] b);
    @(negedge clk);
    instr = i; pc_inc = pc; base_val = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [15:0] acts();
    return {11'b0, mem_rd, mem_wr, jump_valid, link_we, busy};
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle strobes", acts(), 16'h0);
  endtask

  task automatic t_pcrel(input logic store, input logic [8:0] off, input logic [15:0] pc, input string req);
    issue({(store ? 4'b0011 : 4'b0010), 3'd5, off}, pc, 16'h0);
    chk({req, " addr"}, mem_addr, pc + sx({7'b0, off}, 9));
    chk({req, " strobe"}, acts(), store ? 16'h08 : 16'h10);
    chk({req, " reg"}, {13'b0, reg_idx}, 16'd5);
    @(negedge clk);
    chk({req, " one cycle"}, acts(), 16'h0);
  endtask

  task automatic t_base(input logic store, input logic [5:0] off, input logic [15:0] b, input string req);
    issue({(store ? 4'b0111 : 4'b0110), 3'd2, 3'd4, off}, 16'h7777, b);
    chk({req, " addr"}, mem_addr, b + sx({10'b0, off}, 6));
    chk({req, " strobe"}, acts(), store ? 16'h08 : 16'h10);
    chk({req, " reg"}, {13'b0, reg_idx}, 16'd2);
  endtask

  task automatic t_indirect(input logic store, input logic [8:0] off, input logic [15:0] pc, input logic intrude);
    logic [15:0] ptr;
    ptr = pc + sx({7'b0, off}, 9);
    issue({(store ? 4'b1011 : 4'b1010), 3'd6, off}, pc, 16'h0);
    chk("R4 ptr addr", mem_addr, ptr);
    chk("R4 ptr read busy", acts(), 16'h11);
    if (intrude) begin
      instr = 16'h2005; pc_inc = 16'h0100; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(intrude ? "R8 wait ignores start" : "R4 wait", acts(), 16'h01);
    @(negedge clk);
    chk("R4 final addr", mem_addr, scramble(ptr));
    chk("R4 final strobe", acts(), store ? 16'h08 : 16'h10);
    chk("R4 reg", {13'b0, reg_idx}, 16'd6);
    @(negedge clk);
    chk(intrude ? "R8 no extra access" : "R4 done", acts(), 16'h0);
  endtask

  task automatic t_jsr(input logic [10:0] off, input logic [15:0] pc);
    issue({4'b0100, 1'b1, off}, pc, 16'hDEAD);
    chk("R5 target", jump_target, pc + sx({5'b0, off}, 11));
    chk("R5 flags", acts(), 16'h06);
    chk("R5 link data", link_data, pc);
    chk("R5 link reg", {13'b0, reg_idx}, 16'd7);
  endtask

  task automatic t_jsrr(input logic [2:0] br, input logic [15:0] b, input logic [15:0] pc);
    issue({4'b0100, 1'b0, 2'b00, br, 6'b0}, pc, b);
    chk("R6 target", jump_target, b);
    chk("R6 flags", acts(), 16'h06);
    chk("R6 link data", link_data, pc);
  endtask

  task automatic t_jmp(input logic [15:0] b);
    issue({4'b1100, 3'b000, 3'd7, 6'b0}, 16'h4444, b);
    chk("R7 target", jump_target, b);
    chk("R7 no link", acts(), 16'h04);
  endtask

  task automatic t_other(input logic [3:0] opc);
    issue({opc, 12'hFFF}, 16'h1000, 16'h2000);
    chk("R9 no action", acts(), 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog act=%0d exp=done", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_pcrel(1'b0, 9'h005, 16'h3001, "R2 load");
    t_pcrel(1'b1, 9'h100, 16'h3001, "R2 store neg");
    t_pcrel(1'b0, 9'h0FF, 16'hFFF0, "R10 wrap up");
    t_pcrel(1'b1, 9'h1F0, 16'h0004, "R10 wrap down");
    t_base(1'b0, 6'h1F, 16'h8000, "R3 load");
    t_base(1'b1, 6'h20, 16'h0010, "R3 store neg");
    t_base(1'b0, 6'h3F, 16'h0000, "R10 base wrap");
    t_indirect(1'b0, 9'h010, 16'h3000, 1'b0);
    t_indirect(1'b1, 9'h1FE, 16'h0001, 1'b0);
    t_indirect(1'b0, 9'h003, 16'h5000, 1'b1);
    t_jsr(11'h3FF, 16'h3000);
    t_jsr(11'h400, 16'h0100);
    t_jsrr(3'd3, 16'hABCD, 16'h3010);
    t_jsrr(3'd7, 16'h1234, 16'h3020);
    t_jmp(16'h3021);
    t_other(4'b0001);
    t_other(4'b1111);
    @(negedge clk);
    chk("R11 idle end", acts(), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule